// File: doc/BRIEF.md
# Asymmetric Retriggerable Watchdog Timer

This block supervises a host that must retrigger it at regular intervals. While the watchdog is activated and no retrigger arrives, it counts down a lead interval and then drives its output high for a base interval. After that it releases the output and starts a new lead interval. The pattern repeats until a retrigger arrives. The lead interval is always six times the base interval.

Time advances only on cycles where the timebase enable input is high. This enable is expected to pulse 256 times per second. The base interval comes from a 3-bit code held in an 8-bit rate register. The mapping from code to interval is not uniform: code 0 gives a quarter second, code 7 gives half a second, and codes 1 to 6 give short power-of-two fractions. A host writes the rate register to select a timeout, then pulses the retrigger input while it is healthy. The output can drive a reset or an interrupt source elsewhere in the chip.

Top module: `asym_wdog`

## Requirements
- R1: After reset the output is low and the selected code is 0. With the watchdog active and no other stimulus, the first assertion comes 384 timebase ticks after reset is released, and it lasts 64 ticks.
- R2: While `activate_i` is low, the output is low from the next cycle on, and the countdown is held at the full lead interval of the current code. After `activate_i` rises, the output asserts on the lead-interval-th tick, counting the tick in the first active cycle.
- R3: The base interval T, in ticks, is 64 for code 0, 128 for code 7, and 2^(code−1) for codes 1 to 6. The output asserts on the 6×T-th tick after a restart.
- R4: Once asserted, the output stays high for exactly T ticks. It then goes low and a fresh 6×T countdown begins, and this cycle repeats for as long as no retrigger arrives.
- R5: A cycle with `kick_i` high while active drives the output low from the next cycle and restarts the 6×T countdown. This holds whether the output was high or low.
- R6: When `kick_i` is high in the same cycle as the tick that would end the countdown, the retrigger wins: the output stays low and the full countdown restarts.
- R7: A cycle with `wr_en_i` high loads the code from `wr_data_i[6:4]` and ignores the other data bits. It drives the output low from the next cycle and restarts the countdown using the new code. A tick in the write cycle is not counted.
- R8: Cycles with `tick_i` low make no progress. With ticks stopped, the output never asserts.
- R9: A write and a retrigger in the same cycle restart the countdown with the newly written code.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_i | input | 1 | Timebase enable, one pulse per 1/256 s |
| activate_i | input | 1 | Watchdog enable; low holds the output low and the counter at reload |
| kick_i | input | 1 | Retrigger strobe |
| wr_en_i | input | 1 | Rate register write strobe |
| wr_data_i | input | DATA_W | Rate register write data; the code sits at bits 6:4 |
| wd_out_o | output | 1 | Watchdog output, high during the asserted phase |

## Verification
The bound checker checks the following on every cycle:
- Each assertion lands exactly on the 6×T-th counted tick since the last restart, measured by a tick counter the checker keeps for itself.
- No high phase lasts longer than T ticks.
- A rise is always caused by a tick.
- A retrigger, a rate write or deactivation always forces the output low in the next cycle.

Some behaviours only the bench scenarios can show:
- The exact width of each high phase.
- The repetition of the pattern.
- The retrigger winning over a coinciding timeout.
- The use of the new code when a write and a retrigger share a cycle.
- The stall while ticks are stopped.

To cover them, the bench sweeps all eight codes through two full low/high periods each.

// File: rtl/asym_wdog_pkg.sv
package asym_wdog_pkg;

    localparam int CODE_W = 3;
    localparam int NCODES = 1 << CODE_W;

    typedef enum logic {
        PH_WAIT = 1'b0,
        PH_HIGH = 1'b1
    } phase_e;

    // Base interval in ticks for a code, with 2**tick_shift ticks per second.
    function automatic int base_ticks(input int code, input int tick_shift);
        if (code == 0)
            return 1 << (tick_shift - 2);
        else if (code == NCODES - 1)
            return 1 << (tick_shift - 1);
        else
            return 1 << (tick_shift + code - 9);
    endfunction

endpackage

// File: rtl/awd_rate_reg.sv
module awd_rate_reg
    import asym_wdog_pkg::*;
#(
    parameter int DATA_W   = 8,
    parameter int CODE_LSB = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en_i,
    input  logic [DATA_W-1:0] wr_data_i,
    output logic [CODE_W-1:0] code_next_o
);

    typedef struct packed {
        logic [CODE_W-1:0] code;
    } rate_st_t;

    rate_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr_en_i)
            st_d.code = wr_data_i[CODE_LSB +: CODE_W];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            st_q <= '0;
        else
            st_q <= st_d;
    end

    // The code that will hold after this edge: a reload in a write cycle must use the new code.
    assign code_next_o = st_d.code;

endmodule

// File: rtl/awd_interval_map.sv
module awd_interval_map
    import asym_wdog_pkg::*;
#(
    parameter int TICK_SHIFT = 8,
    parameter int RATIO      = 6,
    parameter int CNT_W      = 10
) (
    input  logic [CODE_W-1:0] code_i,
    output logic [CNT_W-1:0]  base_o,
    output logic [CNT_W-1:0]  lead_o
);

    logic [CNT_W-1:0] base_tab [NCODES];
    logic [CNT_W-1:0] lead_tab [NCODES];

    for (genvar g = 0; g < NCODES; g++) begin : g_tab
        assign base_tab[g] = CNT_W'(base_ticks(g, TICK_SHIFT));
        assign lead_tab[g] = CNT_W'(RATIO * base_ticks(g, TICK_SHIFT));
    end

    assign base_o = base_tab[code_i];
    assign lead_o = lead_tab[code_i];

endmodule

// File: rtl/awd_phase_fsm.sv
module awd_phase_fsm
    import asym_wdog_pkg::*;
#(
    parameter int CNT_W     = 10,
    parameter int RST_RELOAD = 384
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_i,
    input  logic             activate_i,
    input  logic             restart_i,
    input  logic [CNT_W-1:0] base_i,
    input  logic [CNT_W-1:0] lead_i,
    output logic             out_o
);

    typedef struct packed {
        phase_e           phase;
        logic [CNT_W-1:0] cnt;
        logic             out;
    } fsm_st_t;

    fsm_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (!activate_i || restart_i) begin
            // Held or restarted: low, full lead interval loaded.
            st_d.phase = PH_WAIT;
            st_d.cnt   = lead_i;
            st_d.out   = 1'b0;
        end else if (tick_i) begin
            if (st_q.cnt <= CNT_W'(1)) begin
                if (st_q.phase == PH_WAIT) begin
                    st_d.phase = PH_HIGH;
                    st_d.cnt   = base_i;
                    st_d.out   = 1'b1;
                end else begin
                    st_d.phase = PH_WAIT;
                    st_d.cnt   = lead_i;
                    st_d.out   = 1'b0;
                end
            end else begin
                st_d.cnt = st_q.cnt - CNT_W'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.phase <= PH_WAIT;
            st_q.cnt   <= CNT_W'(RST_RELOAD);
            st_q.out   <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign out_o = st_q.out;

endmodule

// File: rtl/asym_wdog.sv
module asym_wdog
    import asym_wdog_pkg::*;
#(
    parameter int DATA_W     = 8,
    parameter int CODE_LSB   = 4,
    parameter int TICK_SHIFT = 8,
    parameter int RATIO      = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_i,
    input  logic              activate_i,
    input  logic              kick_i,
    input  logic              wr_en_i,
    input  logic [DATA_W-1:0] wr_data_i,
    output logic              wd_out_o
);

    localparam int MAX_LEAD   = RATIO * (1 << (TICK_SHIFT - 1));
    localparam int CNT_W      = $clog2(MAX_LEAD + 1);
    localparam int RST_RELOAD = RATIO * base_ticks(0, TICK_SHIFT);

    logic [CODE_W-1:0] code_next;
    logic [CNT_W-1:0]  base_ticks_w;
    logic [CNT_W-1:0]  lead_ticks_w;
    logic              restart;

    assign restart = wr_en_i | kick_i;   // R6: checked before the tick in the FSM

    awd_rate_reg #(
        .DATA_W   (DATA_W),
        .CODE_LSB (CODE_LSB)
    ) rate_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_en_i     (wr_en_i),
        .wr_data_i   (wr_data_i),
        .code_next_o (code_next)
    );

    awd_interval_map #(
        .TICK_SHIFT (TICK_SHIFT),
        .RATIO      (RATIO),
        .CNT_W      (CNT_W)
    ) map_i (
        .code_i (code_next),
        .base_o (base_ticks_w),
        .lead_o (lead_ticks_w)
    );

    awd_phase_fsm #(
        .CNT_W      (CNT_W),
        .RST_RELOAD (RST_RELOAD)
    ) fsm_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick_i     (tick_i),
        .activate_i (activate_i),
        .restart_i  (restart),
        .base_i     (base_ticks_w),
        .lead_i     (lead_ticks_w),
        .out_o      (wd_out_o)
    );

endmodule

// File: rtl/awd_checker.sv
module awd_checker #(
    parameter int DATA_W     = 8,
    parameter int CODE_LSB   = 4,
    parameter int TICK_SHIFT = 8,
    parameter int RATIO      = 6
) (
    input logic              clk,
    input logic              rst_n,
    input logic              tick_i,
    input logic              activate_i,
    input logic              kick_i,
    input logic              wr_en_i,
    input logic [DATA_W-1:0] wr_data_i,
    input logic              wd_out_o
);

    logic [2:0]  code_q;
    logic [15:0] t_exp;
    logic [15:0] lead_exp;
    logic [15:0] lo_cnt_q;
    logic [15:0] hi_cnt_q;

    // Checker-side view of the selected code and its intervals
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            code_q <= 3'd0;
        else if (wr_en_i)
            code_q <= wr_data_i[CODE_LSB +: 3];
    end

    always_comb begin
        if (code_q == 3'd0)
            t_exp = 16'd1 << (TICK_SHIFT - 2);
        else if (code_q == 3'd7)
            t_exp = 16'd1 << (TICK_SHIFT - 1);
        else
            t_exp = (16'd1 << (TICK_SHIFT - 1)) >> (4'd8 - {1'b0, code_q});
        lead_exp = 16'(RATIO) * t_exp;
    end

    // Ticks counted since the last restart, while low and active
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            lo_cnt_q <= 16'd0;
        else if (!activate_i || wr_en_i || kick_i || wd_out_o)
            lo_cnt_q <= 16'd0;
        else if (tick_i)
            lo_cnt_q <= lo_cnt_q + 16'd1;
    end

    // Ticks counted during the high phase
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            hi_cnt_q <= 16'd0;
        else if (!wd_out_o)
            hi_cnt_q <= 16'd0;
        else if (tick_i)
            hi_cnt_q <= hi_cnt_q + 16'd1;
    end

    p_idle_low_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !activate_i |=> !wd_out_o);

    p_lead_exact_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wd_out_o) |-> (lo_cnt_q == lead_exp));

    p_high_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
        wd_out_o |-> (hi_cnt_q <= t_exp));

    p_kick_clears_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (activate_i && kick_i) |=> !wd_out_o);

    p_write_clears_r7: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en_i |=> !wd_out_o);

    p_rise_on_tick_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wd_out_o) |-> $past(tick_i));

endmodule

bind asym_wdog awd_checker #(
    .DATA_W     (DATA_W),
    .CODE_LSB   (CODE_LSB),
    .TICK_SHIFT (TICK_SHIFT),
    .RATIO      (RATIO)
) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .tick_i     (tick_i),
    .activate_i (activate_i),
    .kick_i     (kick_i),
    .wr_en_i    (wr_en_i),
    .wr_data_i  (wr_data_i),
    .wd_out_o   (wd_out_o)
);

// File: tb/asym_wdog_tb_top.sv
`timescale 1ns/1ps
module asym_wdog_tb_top;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       tick_i;
    logic       activate_i;
    logic       kick_i;
    logic       wr_en_i;
    logic [7:0] wr_data_i;
    logic       wd_out_o;

    int tests = 0;
    int fails = 0;
    int cyc = 0;
    int nticks = 0;
    int tick_div = 1;
    bit tick_en = 1'b1;

    always #2.5 clk = ~clk;

    asym_wdog dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick_i     (tick_i),
        .activate_i (activate_i),
        .kick_i     (kick_i),
        .wr_en_i    (wr_en_i),
        .wr_data_i  (wr_data_i),
        .wd_out_o   (wd_out_o)
    );

    function automatic int t_of(input int c);
        if (c == 0) return 64;
        if (c == 7) return 128;
        return 1 << (c - 1);
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // One clock cycle; inputs change at the falling edge
    task automatic step();
        tick_i = tick_en && ((cyc % tick_div) == 0);
        cyc++;
        @(negedge clk);
        if (tick_i) nticks++;
    endtask

    task automatic wait_level(input bit lvl, output int ticks);
        nticks = 0;
        for (int i = 0; i < 6000; i++) begin
            step();
            if (wd_out_o === lvl) break;
        end
        ticks = nticks;
    endtask

    task automatic write_rate(input logic [7:0] d, input bit with_kick);
        wr_en_i   = 1'b1;
        wr_data_i = d;
        kick_i    = with_kick;
        step();
        wr_en_i = 1'b0;
        kick_i  = 1'b0;
    endtask

    task automatic pulse_kick();
        kick_i = 1'b1;
        step();
        kick_i = 1'b0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        tests++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        int t;
        rst_n      = 1'b0;
        tick_i     = 1'b0;
        activate_i = 1'b1;
        kick_i     = 1'b0;
        wr_en_i    = 1'b0;
        wr_data_i  = 8'h00;
        repeat (4) @(negedge clk);
        check(wd_out_o == 1'b0, "R1 reset low", int'(wd_out_o), 0);
        rst_n = 1'b1;

        // R1: default code 0 after reset
        wait_level(1'b1, t);
        check(t == 384, "R1 first lead", t, 384);
        wait_level(1'b0, t);
        check(t == 64, "R1 first high", t, 64);

        // R3 / R4: sweep all codes over two full periods
        for (int c = 0; c < 8; c++) begin
            write_rate(8'(c << 4), 1'b0);
            for (int rep = 0; rep < 2; rep++) begin
                wait_level(1'b1, t);
                check(t == 6 * t_of(c), "R3 lead", t, 6 * t_of(c));
                wait_level(1'b0, t);
                check(t == t_of(c), "R4 high width", t, t_of(c));
            end
        end

        // R8: sparse ticks, then no ticks
        tick_div = 3;
        write_rate(8'h20, 1'b0);
        wait_level(1'b1, t);
        check(t == 12, "R8 sparse ticks lead", t, 12);
        tick_div = 1;
        write_rate(8'h10, 1'b0);
        tick_en = 1'b0;
        begin
            bit rose = 1'b0;
            for (int i = 0; i < 200; i++) begin
                step();
                if (wd_out_o) rose = 1'b1;
            end
            check(!rose, "R8 stalled without ticks", int'(rose), 0);
        end
        tick_en = 1'b1;
        wait_level(1'b1, t);
        check(t == 6, "R8 resume", t, 6);

        // R5: retrigger during high phase and mid countdown
        write_rate(8'h30, 1'b0);
        wait_level(1'b1, t);
        pulse_kick();
        check(wd_out_o == 1'b0, "R5 kick releases", int'(wd_out_o), 0);
        wait_level(1'b1, t);
        check(t == 24, "R5 restart after high kick", t, 24);
        write_rate(8'h30, 1'b0);
        repeat (10) step();
        pulse_kick();
        wait_level(1'b1, t);
        check(t == 24, "R5 restart mid countdown", t, 24);

        // R6: kick on the timeout tick
        write_rate(8'h20, 1'b0);
        repeat (11) step();
        check(wd_out_o == 1'b0, "R6 before timeout", int'(wd_out_o), 0);
        pulse_kick();
        check(wd_out_o == 1'b0, "R6 kick wins", int'(wd_out_o), 0);
        wait_level(1'b1, t);
        check(t == 12, "R6 full restart", t, 12);

        // R7: code from bits 6:4 only; write during high releases
        write_rate(8'hAF, 1'b0);
        check(wd_out_o == 1'b0, "R7 write releases", int'(wd_out_o), 0);
        wait_level(1'b1, t);
        check(t == 12, "R7 field 0xAF", t, 12);
        write_rate(8'h9D, 1'b0);
        wait_level(1'b1, t);
        check(t == 6, "R7 field 0x9D", t, 6);

        // R9: write and kick together use the new code
        write_rate(8'h40, 1'b1);
        wait_level(1'b1, t);
        check(t == 48, "R9 write plus kick", t, 48);

        // R2: deactivated holds low, resumes with full lead
        write_rate(8'h10, 1'b0);
        activate_i = 1'b0;
        begin
            bit rose = 1'b0;
            for (int i = 0; i < 100; i++) begin
                step();
                if (wd_out_o) rose = 1'b1;
            end
            check(!rose, "R2 inactive low", int'(rose), 0);
        end
        activate_i = 1'b1;
        wait_level(1'b1, t);
        check(t == 6, "R2 lead after activate", t, 6);
        activate_i = 1'b0;
        step();
        check(wd_out_o == 1'b0, "R2 deactivate releases", int'(wd_out_o), 0);
        activate_i = 1'b1;

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule